// File: doc/BRIEF.md
# FPU Constant Push Unit

This block carries out the seven floating-point load-constant operations. A request presents a two-byte opcode whose first byte is D9 and whose second byte lies in E8..EE. The second byte picks one of seven constants, each held with two guard bits below a 64-bit significand. The selected constant is rounded to the 80-bit extended format under the rounding-control field, then pushed onto an eight-slot register stack by moving the top pointer down by one.

Before the push the unit checks the tag of the slot that will become the new top. A slot that is not empty means a stack overflow. On overflow the unit either writes the default quiet NaN, when the invalid exception is masked, or leaves the stack alone. If either coprocessor-control bit (emulate or task-switched) is set, the unit reports a device-not-available fault and changes nothing.

The controller has two states. `S_IDLE` accepts a start strobe that carries a recognised opcode (transition *accept*). `S_DONE` drives the done pulse for one cycle and always returns to `S_IDLE` (transition *finish*). An unrecognised opcode, or no start, keeps `S_IDLE` (transition *hold*).

Top module: `fpc_push_unit`

## Requirements
- R1: With `op_hi`=D9, second bytes E8, E9, EA, EB, EC, ED and EE select, in that order, +1.0, log2(10), log2(e), pi, log10(2), ln(2) and +0.0. Results are 80 bits wide: {sign, 15-bit biased exponent, 64-bit significand with explicit integer bit}.
- R2: With `rc`=00 (nearest), the result is the truncated 64-bit significand plus one whenever the first discarded bit is 1. This gives 4000_D49A784BCD1B8AFE, 3FFF_B8AA3B295C17F0BC, 4000_C90FDAA22168C235, 3FFD_9A209A84FBCFF799 and 3FFE_B17217F7D1CF79AC.
- R3: `rc`=10 (toward +inf) adds one when any discarded bit is nonzero. `rc`=01 (toward -inf) and `rc`=11 (toward zero) drop the discarded bits.
- R4: A push sets `top_ptr` to (top-1) mod 8 and writes the value to the new ST(0). `rd_sel`=i reads ST(i), which is physical slot (top+i) mod 8.
- R5: Tags are 2 bits: 00 valid, 01 zero, 10 special, 11 empty. `tag_word` holds slot k at bits [2k+1:2k]. Reset leaves `top_ptr`=0 and every tag empty. A successful push tags the slot zero for +0.0 and valid otherwise.
- R6: `c1` and `stack_fault` are 1 after a push whose target slot was not empty, and 0 after any other push, including one that rounded up.
- R7: On overflow with `inv_mask`=1, the unit writes the indefinite QNaN FFFF_C000000000000000, tags the slot special and moves the top down.
- R8: On overflow with `inv_mask`=0, top, tags and slot contents stay unchanged.
- R9: With `cr0_em` or `cr0_ts` set, `nm_fault` goes to 1, `c1` and `stack_fault` go to 0, and the stack and top stay unchanged.
- R10: `done` is high for exactly the one cycle after an accepted start. A start with any other opcode gives no `done` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled in idle |
| op_hi | input | 8 | First opcode byte |
| op_lo | input | 8 | Second opcode byte |
| rc | input | 2 | Rounding control |
| inv_mask | input | 1 | Invalid exception masked |
| cr0_em | input | 1 | Emulate bit of control register 0 |
| cr0_ts | input | 1 | Task-switched bit of control register 0 |
| rd_sel | input | 3 | Stack-relative read index |
| done | output | 1 | Completion pulse |
| c1 | output | 1 | Condition bit C1 (overflow indication) |
| stack_fault | output | 1 | Invalid-operation stack fault |
| nm_fault | output | 1 | Device-not-available fault |
| top_ptr | output | 3 | Top-of-stack pointer |
| rd_val | output | 80 | Value of ST(rd_sel) |
| rd_tag | output | 2 | Tag of ST(rd_sel) |
| tag_word | output | 16 | All eight tags by physical slot |

## Verification
Each of the seven opcodes is pushed under all four rounding modes onto an empty stack. This separates constants whose guard bits are 00, 01, 10 and 11, so a swapped mode, a wrong guard-bit test or a misordered decode each give a distinct wrong significand. The stack is then filled eight deep and pushed once more, first with the invalid exception masked and then unmasked, to tell the QNaN write apart from leaving the stack unchanged. Pushes with either control-register bit set, and an out-of-range opcode, show that the stack stays untouched.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int SIG_W   = 64;
    localparam int EXT_W   = 2;
    localparam int EXP_W   = 15;
    localparam int REG_W   = 1 + EXP_W + SIG_W;
    localparam int KSIG_W  = SIG_W + EXT_W;
    localparam int DEPTH   = 8;
    localparam int PTR_W   = $clog2(DEPTH);

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } xreal_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [KSIG_W-1:0] sig;
    } kconst_t;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

    typedef enum logic [1:0] {
        RC_NEAR = 2'b00,
        RC_DOWN = 2'b01,
        RC_UP   = 2'b10,
        RC_CHOP = 2'b11
    } rc_e;

    localparam xreal_t QNAN_INDEF = '{sign: 1'b1, exp: {EXP_W{1'b1}},
                                      sig: {2'b11, {(SIG_W-2){1'b0}}}};
endpackage

// File: rtl/fpc_const_rom.sv
module fpc_const_rom
    import fpc_pkg::*;
(
    input  logic [7:0] op_lo,
    output logic       hit,
    output logic       is_zero,
    output kconst_t    kval
);
    always_comb begin
        hit     = 1'b1;
        is_zero = 1'b0;
        unique case (op_lo)
            8'hE8: kval = '{1'b0, 15'h3FFF, {64'h8000000000000000, 2'b00}};
            8'hE9: kval = '{1'b0, 15'h4000, {64'hD49A784BCD1B8AFE, 2'b01}};
            8'hEA: kval = '{1'b0, 15'h3FFF, {64'hB8AA3B295C17F0BB, 2'b10}};
            8'hEB: kval = '{1'b0, 15'h4000, {64'hC90FDAA22168C234, 2'b11}};
            8'hEC: kval = '{1'b0, 15'h3FFD, {64'h9A209A84FBCFF798, 2'b10}};
            8'hED: kval = '{1'b0, 15'h3FFE, {64'hB17217F7D1CF79AB, 2'b11}};
            8'hEE: begin
                kval    = '0;
                is_zero = 1'b1;
            end
            default: begin
                kval = '0;
                hit  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fpc_round.sv
module fpc_round
    import fpc_pkg::*;
(
    input  kconst_t    kin,
    input  logic [1:0] rc,
    output xreal_t     rout
);
    logic [SIG_W-1:0] trunc;
    logic [EXT_W-1:0] ext;
    logic             inc;
    logic [SIG_W:0]   sum;

    always_comb begin
        trunc = kin.sig[KSIG_W-1:EXT_W];
        ext   = kin.sig[EXT_W-1:0];
        unique case (rc_e'(rc))
            RC_NEAR: inc = ext[EXT_W-1];
            RC_UP:   inc = |ext;
            RC_DOWN,
            RC_CHOP: inc = 1'b0;
        endcase
        sum       = {1'b0, trunc} + {{SIG_W{1'b0}}, inc};
        rout.sign = kin.sign;
        if (sum[SIG_W]) begin
            rout.exp = kin.exp + 1'b1;
            rout.sig = {1'b1, {(SIG_W-1){1'b0}}};
        end else begin
            rout.exp = kin.exp;
            rout.sig = sum[SIG_W-1:0];
        end
    end

    // R3: rounding moves the significand by at most one unit, never down
    always_comb begin
        if (rout.exp == kin.exp)
            assert_round_step_R3: assert ((rout.sig >= trunc) && (rout.sig - trunc <= 1));
    end
endmodule

// File: rtl/fpc_stack.sv
module fpc_stack
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  xreal_t           wr_val,
    input  tag_e             wr_tag,
    input  logic [PTR_W-1:0] rd_sel,
    output logic [PTR_W-1:0] top,
    output tag_e             next_tag,
    output xreal_t           rd_val,
    output tag_e             rd_tag,
    output logic [2*DEPTH-1:0] tag_word
);
    xreal_t           slots [DEPTH];
    tag_e             tags  [DEPTH];
    logic [PTR_W-1:0] new_top;
    logic [PTR_W-1:0] rd_phys;

    always_comb begin
        new_top  = top - 1'b1;
        rd_phys  = top + rd_sel;
        next_tag = tags[new_top];
        rd_val   = slots[rd_phys];
        rd_tag   = tags[rd_phys];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top <= '0;
        end else if (push_en) begin
            top <= new_top;
        end
    end

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tags[k]  <= TAG_EMPTY;
                    slots[k] <= '0;
                end else if (push_en && new_top == PTR_W'(k)) begin
                    tags[k]  <= wr_tag;
                    slots[k] <= wr_val;
                end
            end
            assign tag_word[2*k +: 2] = tags[k];
        end
    endgenerate

    // R4: every push moves the top down by exactly one slot
    assert_top_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> top == PTR_W'($past(top) - 1'b1));

    // R5: the slot a push lands in is never left empty
    assert_slot_filled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> rd_phys != top || rd_tag != TAG_EMPTY || 1'b1 ? tags[top] != TAG_EMPTY : 1'b1);
endmodule

// File: rtl/fpc_push_unit.sv
module fpc_push_unit
    import fpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         op_hi,
    input  logic [7:0]         op_lo,
    input  logic [1:0]         rc,
    input  logic               inv_mask,
    input  logic               cr0_em,
    input  logic               cr0_ts,
    input  logic [PTR_W-1:0]   rd_sel,
    output logic               done,
    output logic               c1,
    output logic               stack_fault,
    output logic               nm_fault,
    output logic [PTR_W-1:0]   top_ptr,
    output logic [REG_W-1:0]   rd_val,
    output logic [1:0]         rd_tag,
    output logic [2*DEPTH-1:0] tag_word
);
    localparam logic [7:0] ESC_BYTE = 8'hD9;

    typedef enum logic [0:0] {S_IDLE, S_DONE} state_e;
    state_e state, state_nx;

    logic    hit, is_zero, accept, nm, ovf, push_en;
    kconst_t kval;
    xreal_t  rounded, wr_val, rd_x;
    tag_e    wr_tag, next_tag, rd_tag_e;

    fpc_const_rom u_rom (.op_lo(op_lo), .hit(hit), .is_zero(is_zero), .kval(kval));
    fpc_round     u_rnd (.kin(kval), .rc(rc), .rout(rounded));

    always_comb begin
        accept  = (state == S_IDLE) && start && (op_hi == ESC_BYTE) && hit;
        nm      = cr0_em | cr0_ts;
        ovf     = (next_tag != TAG_EMPTY);
        push_en = accept && !nm && (!ovf || inv_mask);
        wr_val  = ovf ? QNAN_INDEF : rounded;
        wr_tag  = ovf ? TAG_SPECIAL : (is_zero ? TAG_ZERO : TAG_VALID);
    end

    fpc_stack u_stk (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .wr_val(wr_val),
        .wr_tag(wr_tag), .rd_sel(rd_sel), .top(top_ptr), .next_tag(next_tag),
        .rd_val(rd_x), .rd_tag(rd_tag_e), .tag_word(tag_word)
    );
    assign rd_val = rd_x;
    assign rd_tag = rd_tag_e;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // registered flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1          <= 1'b0;
            stack_fault <= 1'b0;
            nm_fault    <= 1'b0;
        end else if (accept) begin
            nm_fault    <= nm;
            c1          <= !nm && ovf;
            stack_fault <= !nm && ovf;
        end
    end

    // outputs from state
    always_comb begin
        unique case (state)
            S_IDLE: done = 1'b0;
            S_DONE: done = 1'b1;
        endcase
    end

    // R10: done lasts a single cycle
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a disabled coprocessor leaves the top pointer alone
    assert_nm_keeps_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && nm) |=> $stable(top_ptr));

    // R8: unmasked overflow keeps all tags
    assert_unmasked_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !nm && ovf && !inv_mask) |=> $stable(tag_word));

    // R6: C1 reports exactly the overflow seen at acceptance
    assert_c1_tracks_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !nm) |=> c1 == $past(ovf));
endmodule

// File: tb/fpc_push_unit_bench.sv
module fpc_push_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_hi = 8'hD9, op_lo = 8'hE8;
    logic [1:0]  rc = 2'b00;
    logic        inv_mask = 1'b1, cr0_em = 1'b0, cr0_ts = 1'b0;
    logic [2:0]  rd_sel = 3'd0;
    logic        done, c1, stack_fault, nm_fault;
    logic [2:0]  top_ptr;
    logic [79:0] rd_val;
    logic [1:0]  rd_tag;
    logic [15:0] tag_word;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fpc_push_unit u_fpc_push_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_hi(op_hi), .op_lo(op_lo),
        .rc(rc), .inv_mask(inv_mask), .cr0_em(cr0_em), .cr0_ts(cr0_ts),
        .rd_sel(rd_sel), .done(done), .c1(c1), .stack_fault(stack_fault),
        .nm_fault(nm_fault), .top_ptr(top_ptr), .rd_val(rd_val), .rd_tag(rd_tag),
        .tag_word(tag_word)
    );

    // {op_lo, rc, expected 80-bit result}
    localparam logic [89:0] VEC [28] = '{
        {8'hE8, 2'd0, 80'h3FFF8000000000000000}, {8'hE8, 2'd1, 80'h3FFF8000000000000000},
        {8'hE8, 2'd2, 80'h3FFF8000000000000000}, {8'hE8, 2'd3, 80'h3FFF8000000000000000},
        {8'hE9, 2'd0, 80'h4000D49A784BCD1B8AFE}, {8'hE9, 2'd1, 80'h4000D49A784BCD1B8AFE},
        {8'hE9, 2'd2, 80'h4000D49A784BCD1B8AFF}, {8'hE9, 2'd3, 80'h4000D49A784BCD1B8AFE},
        {8'hEA, 2'd0, 80'h3FFFB8AA3B295C17F0BC}, {8'hEA, 2'd1, 80'h3FFFB8AA3B295C17F0BB},
        {8'hEA, 2'd2, 80'h3FFFB8AA3B295C17F0BC}, {8'hEA, 2'd3, 80'h3FFFB8AA3B295C17F0BB},
        {8'hEB, 2'd0, 80'h4000C90FDAA22168C235}, {8'hEB, 2'd1, 80'h4000C90FDAA22168C234},
        {8'hEB, 2'd2, 80'h4000C90FDAA22168C235}, {8'hEB, 2'd3, 80'h4000C90FDAA22168C234},
        {8'hEC, 2'd0, 80'h3FFD9A209A84FBCFF799}, {8'hEC, 2'd1, 80'h3FFD9A209A84FBCFF798},
        {8'hEC, 2'd2, 80'h3FFD9A209A84FBCFF799}, {8'hEC, 2'd3, 80'h3FFD9A209A84FBCFF798},
        {8'hED, 2'd0, 80'h3FFEB17217F7D1CF79AC}, {8'hED, 2'd1, 80'h3FFEB17217F7D1CF79AB},
        {8'hED, 2'd2, 80'h3FFEB17217F7D1CF79AC}, {8'hED, 2'd3, 80'h3FFEB17217F7D1CF79AB},
        {8'hEE, 2'd0, 80'h00000000000000000000}, {8'hEE, 2'd1, 80'h00000000000000000000},
        {8'hEE, 2'd2, 80'h00000000000000000000}, {8'hEE, 2'd3, 80'h00000000000000000000}
    };

    localparam logic [79:0] QNAN = 80'hFFFFC000000000000000;

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ends on the negedge of the done cycle
    task automatic do_push(input logic [7:0] hi, input logic [7:0] lo, input logic [1:0] r,
                           input logic m, input logic em, input logic ts);
        @(negedge clk);
        op_hi = hi; op_lo = lo; rc = r; inv_mask = m; cr0_em = em; cr0_ts = ts;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R5: reset state
        chk("R5", {77'd0, top_ptr}, 80'd0);
        chk("R5", {64'd0, tag_word}, {64'd0, 16'hFFFF});
        chk("R10", {79'd0, done}, 80'd0);

        // table walk: R1, R2, R3, R4, R5, R6, R10
        for (int i = 0; i < 28; i++) begin
            do_reset();
            do_push(8'hD9, VEC[i][89:82], VEC[i][81:80], 1'b1, 1'b0, 1'b0);
            chk("R10", {79'd0, done}, 80'd1);
            chk(VEC[i][81:80] == 2'd0 ? "R2" : "R3", rd_val, VEC[i][79:0]);
            chk("R4", {77'd0, top_ptr}, 80'd7);
            chk("R5", {78'd0, rd_tag}, VEC[i][89:82] == 8'hEE ? 80'd1 : 80'd0);
            chk("R6", {78'd0, c1, stack_fault}, 80'd0);
            @(negedge clk);
            chk("R10", {79'd0, done}, 80'd0);
        end

        // R4: ST(1) after two pushes
        do_reset();
        do_push(8'hD9, 8'hE8, 2'd0, 1'b1, 1'b0, 1'b0);
        do_push(8'hD9, 8'hEB, 2'd0, 1'b1, 1'b0, 1'b0);
        rd_sel = 3'd1;
        #1;
        chk("R4", rd_val, 80'h3FFF8000000000000000);
        rd_sel = 3'd0;
        chk("R4", {77'd0, top_ptr}, 80'd6);

        // R10: unrecognised opcodes are ignored
        do_push(8'hD9, 8'hEF, 2'd0, 1'b1, 1'b0, 1'b0);
        chk("R10", {79'd0, done}, 80'd0);
        do_push(8'hD8, 8'hE8, 2'd0, 1'b1, 1'b0, 1'b0);
        chk("R10", {79'd0, done}, 80'd0);
        chk("R10", {77'd0, top_ptr}, 80'd6);
        chk("R10", {64'd0, tag_word}, {64'd0, 16'h0FFF});

        // fill to eight entries
        do_reset();
        for (int n = 0; n < 8; n++) begin
            do_push(8'hD9, 8'hE8, 2'd0, 1'b1, 1'b0, 1'b0);
        end
        chk("R4", {77'd0, top_ptr}, 80'd0);
        chk("R5", {64'd0, tag_word}, 80'd0);

        // R7: masked overflow
        do_push(8'hD9, 8'hEB, 2'd0, 1'b1, 1'b0, 1'b0);
        chk("R6", {78'd0, c1, stack_fault}, 80'd3);
        chk("R7", rd_val, QNAN);
        chk("R7", {78'd0, rd_tag}, 80'd2);
        chk("R7", {77'd0, top_ptr}, 80'd7);

        // R8: unmasked overflow
        do_push(8'hD9, 8'hEE, 2'd0, 1'b0, 1'b0, 1'b0);
        chk("R10", {79'd0, done}, 80'd1);
        chk("R8", {78'd0, c1, stack_fault}, 80'd3);
        chk("R8", {77'd0, top_ptr}, 80'd7);
        chk("R8", rd_val, QNAN);
        chk("R8", {64'd0, tag_word}, {64'd0, 16'h8000});

        // R9: emulate bit, then task-switched bit
        do_push(8'hD9, 8'hE8, 2'd0, 1'b1, 1'b1, 1'b0);
        chk("R9", {77'd0, nm_fault, c1, stack_fault}, 80'd4);
        chk("R9", {77'd0, top_ptr}, 80'd7);
        do_reset();
        do_push(8'hD9, 8'hE9, 2'd0, 1'b1, 1'b0, 1'b1);
        chk("R10", {79'd0, done}, 80'd1);
        chk("R9", {79'd0, nm_fault}, 80'd1);
        chk("R9", {77'd0, top_ptr}, 80'd0);
        chk("R9", {64'd0, tag_word}, {64'd0, 16'hFFFF});

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule